// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host bus and the write engine of a modelled NOR flash. The host issues writes (chip-enable and write-enable low, then write-enable released) that carry a command byte in the low data byte. The controller turns these writes into read-mode changes, status clears, and operations for a write engine: block erase, word program, suspend and resume. A read (chip-enable and output-enable both low) returns array data, an identifier code or the status byte, depending on the current read mode.

The write engine is a plain countdown that stays busy for a fixed number of cycles. A fault input, sampled when the engine finishes, models a failed operation. The status byte has live bits for ready and suspend state and sticky bits for failures. Array cells are not modelled, so array reads return the erased value FFFFh. A write strobe is recognised at the first clock edge that sees write-enable high after it was low, with chip-enable low. Address and data are taken at that edge. Bank I covers word addresses below 20000h and bank II covers the rest.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset and after command FFh, reads return FFFFh (array mode). Starting an erase or program switches reads to status mode.
- R2: After command 90h, a read at address 0 returns 001Ch and a read at address 1 returns 88C2h.
- R3: After command 70h, reads return the status byte in bits 7:0. The byte is captured at the clock edge that first sees both chip-enable and output-enable low. It does not change while both stay low.
- R4: Status bit 5 (erase failed), bit 4 (program failed) and bit 1 (block rejected) are sticky. Command 50h clears them. No other command or event clears them.
- R5: Command 20h followed by D0h starts an erase. Bit 7 (ready) reads 0 while the engine runs and returns to 1 when it finishes.
- R6: If the write after 20h is not D0h, no erase starts, bits 5 and 4 are set, and the controller returns to idle.
- R7: Command 40h followed by a data write to a bank I address starts a program. A bank II address starts nothing and sets bits 4 and 1.
- R8: During a running operation, B0h written to an address in the same bank suspends it. Bit 7 then reads 1, and bit 6 is set for an erase or bit 2 for a program. B0h to the other bank is ignored. While suspended, FFh allows array reads. D0h to the same bank resumes the operation and selects status mode.
- R9: While the engine runs, every command except 70h and B0h is ignored.
- R10: If the fault input is high when the engine finishes, bit 5 is set for an erase and bit 4 for a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low; a write completes when it rises |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | 20 | Word address |
| bus_din | input | 16 | Write data; command in bits 7:0 |
| bus_dout | output | 16 | Read data; 0 when no read is active |
| engine_fault | input | 1 | Fault result, sampled when the engine finishes |

## Verification
The assertions check on every cycle that an erase starts only from the confirm state with D0h present, that a program starts only from the data state with a bank I address, and that the engine is never started while active. They also check that status mode follows every start, that a suspend matches the bank of the running operation, that sticky bits hold until a clear, and that the captured status stays fixed during one read. The bench scenarios cover the rest: the identifier codes, the failure encodings after a bad confirm or a bank II program, fault reporting per operation type, the full suspend, array-read and resume sequence, and commands ignored while busy.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_STATUS} rd_mode_e;
  typedef enum logic [1:0] {CS_IDLE, CS_ERASE_CONF, CS_PROG_DATA} cmd_state_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
endpackage

// File: rtl/fcc_bus_sense.sv
module fcc_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ce_n,
  input  logic bus_we_n,
  input  logic bus_oe_n,
  output logic wr_stb,
  output logic rd_on,
  output logic rd_rise
);
  logic we_q, rd_q;

  assign rd_on   = ~bus_ce_n & ~bus_oe_n;
  assign wr_stb  = ~bus_ce_n & bus_we_n & ~we_q;
  assign rd_rise = rd_on & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      rd_q <= 1'b0;
    end else begin
      we_q <= bus_we_n;
      rd_q <= rd_on;
    end
  end
endmodule

// File: rtl/fcc_write_engine.sv
module fcc_write_engine #(
  parameter int BUSY_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_erase,
  input  logic suspend,
  input  logic resume,
  output logic active,
  output logic suspended,
  output logic op_erase,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic active_q, active_d, susp_q, susp_d, erase_q, erase_d;

  assign done      = active_q & ~susp_q & (cnt_q == '0);
  assign active    = active_q;
  assign suspended = susp_q;
  assign op_erase  = erase_q;

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    susp_d   = susp_q;
    erase_d  = erase_q;
    if (start && !active_q) begin
      active_d = 1'b1;
      cnt_d    = CNT_TOP;
      erase_d  = start_erase;
    end else if (active_q) begin
      if (susp_q) begin
        if (resume) susp_d = 1'b0;
      end else if (suspend) begin
        susp_d = 1'b1;
      end else if (done) begin
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      susp_q   <= 1'b0;
      erase_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      susp_q   <= susp_d;
      erase_q  <= erase_d;
    end
  end

  p_susp_in_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> active_q);
  p_resume_when_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> susp_q);
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);
  p_susp_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_q && !resume) |=> $stable(cnt_q));
endmodule

// File: rtl/fcc_status_reg.sv
module fcc_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_efail,
  input  logic set_pfail,
  input  logic set_blk,
  input  logic clear,
  output logic efail,
  output logic pfail,
  output logic blk
);
  logic efail_d, pfail_d, blk_d;

  always_comb begin
    efail_d = set_efail | (efail & ~clear);
    pfail_d = set_pfail | (pfail & ~clear);
    blk_d   = set_blk   | (blk   & ~clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      efail <= 1'b0;
      pfail <= 1'b0;
      blk   <= 1'b0;
    end else begin
      efail <= efail_d;
      pfail <= pfail_d;
      blk   <= blk_d;
    end
  end

  p_sticky_efail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (efail && !clear) |=> efail);
  p_sticky_pfail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pfail && !clear) |=> pfail);
  p_sticky_blk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !clear) |=> blk);
  p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !set_efail && !set_pfail && !set_blk) |=> (!efail && !pfail && !blk));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fci_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          BANK1_WORDS = 131072,
  parameter int          BUSY_CYCLES = 32,
  parameter logic [15:0] MFR_CODE    = 16'h001C,
  parameter logic [15:0] DEV_CODE    = 16'h88C2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_din,
  output logic [15:0]       bus_dout,
  input  logic              engine_fault
);
  localparam logic [ADDR_W-1:0] BANK1_LIM = ADDR_W'(BANK1_WORDS);

  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic wr_stb, rd_on, rd_rise;
  fcc_bus_sense i_sense (
    .clk(clk), .rst_n(rst_i), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .wr_stb(wr_stb), .rd_on(rd_on), .rd_rise(rd_rise)
  );

  logic eng_start, start_erase, susp_req, res_req;
  logic eng_active, eng_susp, eng_erase, eng_done, running;
  fcc_write_engine #(.BUSY_CYCLES(BUSY_CYCLES)) i_engine (
    .clk(clk), .rst_n(rst_i), .start(eng_start), .start_erase(start_erase),
    .suspend(susp_req), .resume(res_req), .active(eng_active),
    .suspended(eng_susp), .op_erase(eng_erase), .done(eng_done)
  );
  assign running = eng_active & ~eng_susp;

  logic bad_conf, bank_rej, clr_req, efail, pfail, blk;
  fcc_status_reg i_status (
    .clk(clk), .rst_n(rst_i),
    .set_efail(bad_conf | (eng_done & eng_erase & engine_fault)),
    .set_pfail(bad_conf | bank_rej | (eng_done & ~eng_erase & engine_fault)),
    .set_blk(bank_rej), .clear(clr_req),
    .efail(efail), .pfail(pfail), .blk(blk)
  );

  cmd_state_e state_q, state_d;
  rd_mode_e   mode_q, mode_d;
  logic       op_bank_q, op_bank_d;
  logic [7:0] cmd, stat_live, stat_lat;
  logic       wr_bank;
  logic       unused_hi;

  assign cmd       = bus_din[7:0];
  assign unused_hi = ^bus_din[15:8];
  assign wr_bank   = (bus_addr >= BANK1_LIM);
  assign stat_live = {~running, eng_susp & eng_erase, efail, pfail,
                      1'b0, eng_susp & ~eng_erase, blk, 1'b0};

  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    op_bank_d   = op_bank_q;
    eng_start   = 1'b0;
    start_erase = 1'b0;
    susp_req    = 1'b0;
    res_req     = 1'b0;
    bad_conf    = 1'b0;
    bank_rej    = 1'b0;
    clr_req     = 1'b0;
    if (wr_stb) begin
      if (running) begin
        if (cmd == CMD_STATUS) begin
          mode_d = RD_STATUS;
        end else if (cmd == CMD_SUSPEND && wr_bank == op_bank_q) begin
          susp_req = 1'b1;
          mode_d   = RD_STATUS;
        end
      end else begin
        unique case (state_q)
          CS_ERASE_CONF: begin
            state_d = CS_IDLE;
            mode_d  = RD_STATUS;
            if (cmd == CMD_CONFIRM) begin
              eng_start   = 1'b1;
              start_erase = 1'b1;
              op_bank_d   = wr_bank;
            end else begin
              bad_conf = 1'b1;
            end
          end
          CS_PROG_DATA: begin
            state_d = CS_IDLE;
            mode_d  = RD_STATUS;
            if (!wr_bank) begin
              eng_start = 1'b1;
              op_bank_d = 1'b0;
            end else begin
              bank_rej = 1'b1;
            end
          end
          default: begin
            case (cmd)
              CMD_ARRAY:   mode_d  = RD_ARRAY;
              CMD_IDENT:   mode_d  = RD_IDENT;
              CMD_STATUS:  mode_d  = RD_STATUS;
              CMD_CLEAR:   clr_req = 1'b1;
              CMD_ERASE:   if (!eng_susp) state_d = CS_ERASE_CONF;
              CMD_PROGRAM: if (!eng_susp) state_d = CS_PROG_DATA;
              CMD_CONFIRM: if (eng_susp && wr_bank == op_bank_q) begin
                res_req = 1'b1;
                mode_d  = RD_STATUS;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q   <= CS_IDLE;
      mode_q    <= RD_ARRAY;
      op_bank_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      mode_q    <= mode_d;
      op_bank_q <= op_bank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       stat_lat <= 8'h00;
    else if (rd_rise) stat_lat <= stat_live;
  end

  always_comb begin
    bus_dout = 16'h0000;
    if (rd_on) begin
      case (mode_q)
        RD_IDENT:  bus_dout = (bus_addr == '0) ? MFR_CODE :
                              (bus_addr == ADDR_W'(1)) ? DEV_CODE : 16'h0000;
        RD_STATUS: bus_dout = {8'h00, stat_lat};
        default:   bus_dout = 16'hFFFF;
      endcase
    end
  end

  p_auto_status_r1: assert property (@(posedge clk) disable iff (!rst_i)
    eng_start |=> (mode_q == RD_STATUS));
  p_erase_needs_conf_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (eng_start && start_erase) |-> (state_q == CS_ERASE_CONF && cmd == CMD_CONFIRM));
  p_bad_conf_idle_r6: assert property (@(posedge clk) disable iff (!rst_i)
    bad_conf |=> (state_q == CS_IDLE && !eng_active));
  p_prog_bank1_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (eng_start && !start_erase) |-> (state_q == CS_PROG_DATA && !wr_bank));
  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_i)
    eng_start |-> !eng_active);
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_stb && running && cmd != CMD_STATUS && cmd != CMD_SUSPEND)
      |=> ($stable(mode_q) && $stable(state_q)));
  p_susp_bank_r8: assert property (@(posedge clk) disable iff (!rst_i)
    susp_req |-> (wr_bank == op_bank_q && running));
  p_stat_hold_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_on && !rd_rise) |=> $stable(stat_lat));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        fault = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        finished = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
    .bus_oe_n(oe_n), .bus_addr(addr), .bus_din(din), .bus_dout(dout),
    .engine_fault(fault)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [19:0] a, output logic [15:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    @(negedge clk); d = dout;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wait_ready();
    logic [15:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(20'h0, s);
      if (s[7]) break;
    end
  endtask

  task automatic t_reset_ident();
    logic [15:0] v;
    rd(20'h00123, v); check("R1 array after reset", v, 16'hFFFF);
    wr(20'h0, 16'h0090);
    rd(20'h0, v); check("R2 manufacturer code", v, 16'h001C);
    rd(20'h1, v); check("R2 device code", v, 16'h88C2);
    wr(20'h0, 16'h00FF);
    rd(20'h1, v); check("R1 array after FFh", v, 16'hFFFF);
    wr(20'h0, 16'h0070);
    rd(20'h0, v); check("R3 idle status", v, 16'h0080);
  endtask

  task automatic t_erase_latch();
    logic [15:0] v;
    wr(20'h0, 16'h00FF);
    wr(20'h30000, 16'h0020);
    wr(20'h30000, 16'h00D0);
    rd(20'h0, v); check("R1 R5 auto status busy", v, 16'h0000);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    repeat (40) @(negedge clk);
    check("R3 status held during read", dout, 16'h0000);
    oe_n = 1'b1; ce_n = 1'b1;
    rd(20'h0, v); check("R3 R5 new read sees ready", v, 16'h0080);
  endtask

  task automatic t_bad_confirm();
    logic [15:0] v;
    wr(20'h30000, 16'h0020);
    wr(20'h30000, 16'h0055);
    rd(20'h0, v); check("R6 bad confirm bits", v, 16'h00B0);
    wr(20'h0, 16'h00FF); wr(20'h0, 16'h0070);
    rd(20'h0, v); check("R4 sticky survives FFh/70h", v, 16'h00B0);
    wr(20'h0, 16'h0050);
    rd(20'h0, v); check("R4 clear", v, 16'h0080);
  endtask

  task automatic t_program();
    logic [15:0] v;
    wr(20'h0, 16'h0040);
    wr(20'h00100, 16'h1234);
    rd(20'h0, v); check("R7 bank I program busy", v, 16'h0000);
    wait_ready();
    rd(20'h0, v); check("R7 program done clean", v, 16'h0080);
    wr(20'h0, 16'h0040);
    wr(20'h40000, 16'h5678);
    rd(20'h0, v); check("R7 bank II rejected", v, 16'h0092);
    wr(20'h0, 16'h0050);
  endtask

  task automatic t_fault();
    logic [15:0] v;
    fault = 1'b1;
    wr(20'h30000, 16'h0020); wr(20'h30000, 16'h00D0);
    wait_ready();
    rd(20'h0, v); check("R10 erase fault", v, 16'h00A0);
    wr(20'h0, 16'h0050);
    wr(20'h0, 16'h0040); wr(20'h00200, 16'hAAAA);
    wait_ready();
    rd(20'h0, v); check("R10 program fault", v, 16'h0090);
    wr(20'h0, 16'h0050);
    fault = 1'b0;
  endtask

  task automatic t_suspend();
    logic [15:0] v;
    wr(20'h30000, 16'h0020); wr(20'h30000, 16'h00D0);
    wr(20'h00100, 16'h00B0);
    rd(20'h0, v); check("R8 wrong-bank suspend ignored", v, 16'h0000);
    wr(20'h30000, 16'h00B0);
    rd(20'h0, v); check("R8 erase suspended", v, 16'h00C0);
    wr(20'h0, 16'h00FF);
    rd(20'h50000, v); check("R8 array read while suspended", v, 16'hFFFF);
    wr(20'h30000, 16'h00D0);
    rd(20'h0, v); check("R8 resumed busy", v, 16'h0000);
    wait_ready();
    rd(20'h0, v); check("R8 erase finishes", v, 16'h0080);
    wr(20'h0, 16'h0040); wr(20'h00100, 16'h0001);
    wr(20'h00200, 16'h00B0);
    rd(20'h0, v); check("R8 program suspended", v, 16'h0084);
    wr(20'h00200, 16'h00D0);
    wait_ready();
    rd(20'h0, v); check("R8 program finishes", v, 16'h0080);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    wr(20'h30000, 16'h0020); wr(20'h30000, 16'h0011);
    wr(20'h30000, 16'h0020); wr(20'h30000, 16'h00D0);
    wr(20'h0, 16'h0090);
    rd(20'h0, v); check("R9 90h ignored while busy", v, 16'h0030);
    wr(20'h0, 16'h0050);
    wait_ready();
    rd(20'h0, v); check("R9 50h ignored while busy", v, 16'h00B0);
    wr(20'h0, 16'h0050);
    rd(20'h0, v); check("R4 clear after busy", v, 16'h0080);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_ident();
    t_erase_latch();
    t_bad_confirm();
    t_program();
    t_fault();
    t_suspend();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule